// File: doc/BRIEF.md
# Binary Seconds Real-Time Clock with Masked Alarm

This peripheral keeps time as a single wide binary count of seconds. A reference-clock enable feeds a programmable prescaler; each time the prescaler reaches its programmed limit it emits one tick, and the seconds counter advances by one. Everything runs on the bus clock. The reference clock appears only as a one-cycle enable input.

Software talks to the block over a simple 32-bit register bus with write strobe, read strobe, byte address and data. A new time is never written straight into the live counter. Software first places it in two staging registers and then issues an upload command. A two-state sequencer (`UPL_IDLE`, `UPL_COPY`) performs the copy and reports completion. Commands in the control word are separate set and clear bits, so writing a zero bit never disturbs anything.

An alarm comparator checks each newly ticked count against a stored alarm value. Only the bit positions enabled in a compare mask take part. A match latches a pending flag, which drives a level interrupt when the mode word enables wake. The mode word can also make the counter halt on the wake event.

Sequencer transitions:
- `UPL_IDLE` goes to `UPL_COPY` on an upload command.
- `UPL_COPY` stays in `UPL_COPY` on a repeated upload command.
- `UPL_COPY` otherwise returns to `UPL_IDLE` after one cycle.

Top module: `bin_rtc`

## Requirements
- R1: After reset the counter is stopped and cleared, the prescaler count is zero, the alarm is disarmed and `irq_o` is low. The control (0x00), mode (0x04) and datetime (0x20, 0x24) registers all read 0.
- R2: Writing control bit0 starts counting and writing control bit1 stops it; when both are written together, stop wins. Control read bit0 shows whether the counter is running.
- R3: While running, a tick occurs once per (prescaler value + 1) cycles in which `ref_en` is high. With `ref_en` low, the count does not move.
- R4: Reading 0x20 returns live count bits 31:0. Reading 0x24 returns count bits 61:32 in bits 29:0, with bits 31:30 as zero.
- R5: Writes to 0x20/0x24 only stage a value. Writing control bit5 copies the staged value into the counter on the next clock edge and restarts the prescaler count. Control read bit5 is 0 from the command until the copy and 1 afterwards.
- R6: Control bit2 arms the alarm, and control read bit2 shows the armed state. When a tick produces a count whose bits equal the alarm value (0x0C low, 0x10 bits 10:0 high) in every position set in the compare mask (0x14 low, 0x18 bits 29:0 high), a pending flag sets on that same edge. The flag stays set while no clear is issued.
- R7: Control bit3 disarms the alarm and clears the pending flag. If it lands on the same edge as a match, the flag stays clear.
- R8: `irq_o` is the pending flag gated by mode bit1. Clearing mode bit1 hides the interrupt without losing the pending flag.
- R9: When a match sets the flag with mode bit1 set, the counter stops if mode bit3 is 0 and keeps counting if mode bit3 is 1.
- R10: Mode bit0 is stored and read back, but counting stays plain binary increment.
- R11: The prescaler register (0x08) keeps 26 bits, alarm high keeps 11 bits and compare high keeps 30 bits. All unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also clocks the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle enable marking a reference clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data is zero when low |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the addressed register |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
The critical same-cycle collision is a disarm command arriving on exactly the clock edge where a tick would produce a matching count. The bench provokes it by counting the prescaler period from a known start edge and placing the control write so its edge coincides with the tick. The result passes only if the counter still advances and `irq_o` stays low afterwards. A second overlap, the upload command versus a running prescaler, is judged by checking that the first tick after an upload lands exactly one full prescaler period after the start.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BUS_W = 32;

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_MODE   = 8'h04;
    localparam logic [7:0] A_PRESC  = 8'h08;
    localparam logic [7:0] A_ALM_LO = 8'h0C;
    localparam logic [7:0] A_ALM_HI = 8'h10;
    localparam logic [7:0] A_CMP_LO = 8'h14;
    localparam logic [7:0] A_CMP_HI = 8'h18;
    localparam logic [7:0] A_DT_LO  = 8'h20;
    localparam logic [7:0] A_DT_HI  = 8'h24;

    // control command / status bit positions
    localparam int C_START   = 0;
    localparam int C_STOP    = 1;
    localparam int C_ALM_ON  = 2;
    localparam int C_ALM_OFF = 3;
    localparam int C_UPLOAD  = 5;

    // mode bit positions
    localparam int M_CAL  = 0;
    localparam int M_WAKE = 1;
    localparam int M_CONT = 3;
    localparam int MODE_W = 4;

    typedef enum logic {UPL_IDLE, UPL_COPY} upl_state_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ref_en,
    input  logic          restart,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    logic [PW-1:0] cnt_q;
    logic          adv;

    assign adv  = run & ref_en & ~restart;
    assign tick = adv && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
    parameter int TW = 62
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] count,
    output logic [TW-1:0] count_next
);
    assign count_next = count + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick)
            count <= count_next;
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int TW = 62
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_on,
    input  logic          arm_off,
    input  logic          tick,
    input  logic [TW-1:0] cand,
    input  logic [TW-1:0] alarm,
    input  logic [TW-1:0] mask,
    output logic          armed,
    output logic          pend,
    output logic          hit
);
    logic match;

    assign match = (((cand ^ alarm) & mask) == '0);
    assign hit   = tick & armed & match & ~arm_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            pend  <= 1'b0;
        end else begin
            if (arm_off)
                armed <= 1'b0;
            else if (arm_on)
                armed <= 1'b1;

            if (arm_off)
                pend <= 1'b0;
            else if (hit)
                pend <= 1'b1;
        end
    end
endmodule

// File: rtl/bin_rtc.sv
module bin_rtc
    import rtc_pkg::*;
#(
    parameter int PRESC_W = 26,
    parameter int TIME_W  = 62,
    parameter int ALARM_W = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq_o
);
    localparam int HI_W  = TIME_W - BUS_W;
    localparam int AHI_W = ALARM_W - BUS_W;

    logic [MODE_W-1:0]  mode_q;
    logic [PRESC_W-1:0] presc_q;
    logic [ALARM_W-1:0] alm_q;
    logic [TIME_W-1:0]  cmp_q;
    logic [TIME_W-1:0]  stage_q;
    logic               run_q;
    logic               done_q;
    upl_state_t         upl_q, upl_d;

    logic              ctrl_wr, up_cmd, do_load, tick, tick_ok;
    logic              armed, pend, hit, arm_off, wake_en, wake_halt;
    logic [TIME_W-1:0] count, count_next, alarm_ext;

    assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
    assign up_cmd    = ctrl_wr && bus_wdata[C_UPLOAD];
    assign arm_off   = ctrl_wr && bus_wdata[C_ALM_OFF];
    assign wake_en   = mode_q[M_WAKE];
    assign alarm_ext = {{(TIME_W-ALARM_W){1'b0}}, alm_q};
    assign tick_ok   = tick & ~do_load;
    assign wake_halt = hit & wake_en & ~mode_q[M_CONT];
    assign irq_o     = pend & wake_en;

    // upload sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upl_q <= UPL_IDLE;
        else        upl_q <= upl_d;
    end

    // upload sequencer: next state
    always_comb begin
        upl_d = upl_q;
        unique case (upl_q)
            UPL_IDLE: if (up_cmd) upl_d = UPL_COPY;
            UPL_COPY: upl_d = up_cmd ? UPL_COPY : UPL_IDLE;
        endcase
    end

    // upload sequencer: outputs
    always_comb begin
        do_load = 1'b0;
        unique case (upl_q)
            UPL_IDLE: do_load = 1'b0;
            UPL_COPY: do_load = 1'b1;
        endcase
    end

    // register file and run control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            presc_q <= '0;
            alm_q   <= '0;
            cmp_q   <= '0;
            stage_q <= '0;
            run_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (bus_wr) begin
                unique case (bus_addr)
                    A_MODE:   mode_q  <= bus_wdata[MODE_W-1:0];
                    A_PRESC:  presc_q <= bus_wdata[PRESC_W-1:0];
                    A_ALM_LO: alm_q[BUS_W-1:0] <= bus_wdata;
                    A_ALM_HI: alm_q[ALARM_W-1:BUS_W] <= bus_wdata[AHI_W-1:0];
                    A_CMP_LO: cmp_q[BUS_W-1:0] <= bus_wdata;
                    A_CMP_HI: cmp_q[TIME_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
                    A_DT_LO:  stage_q[BUS_W-1:0] <= bus_wdata;
                    A_DT_HI:  stage_q[TIME_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
                    default: ;
                endcase
            end
            if (ctrl_wr && bus_wdata[C_STOP])
                run_q <= 1'b0;
            else if (ctrl_wr && bus_wdata[C_START])
                run_q <= 1'b1;
            else if (wake_halt)
                run_q <= 1'b0;
            if (up_cmd)
                done_q <= 1'b0;
            else if (do_load)
                done_q <= 1'b1;
        end
    end

    rtc_prescaler #(.PW(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run_q), .ref_en(ref_en),
        .restart(do_load), .limit(presc_q), .tick(tick)
    );

    rtc_seconds #(.TW(TIME_W)) u_secs (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(do_load),
        .load_val(stage_q), .count(count), .count_next(count_next)
    );

    rtc_alarm_match #(.TW(TIME_W)) u_alarm (
        .clk(clk), .rst_n(rst_n),
        .arm_on(ctrl_wr && bus_wdata[C_ALM_ON]), .arm_off(arm_off),
        .tick(tick_ok), .cand(count_next), .alarm(alarm_ext), .mask(cmp_q),
        .armed(armed), .pend(pend), .hit(hit)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_CTRL: begin
                    bus_rdata[C_START]  = run_q;
                    bus_rdata[C_ALM_ON] = armed;
                    bus_rdata[C_UPLOAD] = done_q;
                end
                A_MODE:   bus_rdata = BUS_W'(mode_q);
                A_PRESC:  bus_rdata = BUS_W'(presc_q);
                A_ALM_LO: bus_rdata = alm_q[BUS_W-1:0];
                A_ALM_HI: bus_rdata = BUS_W'(alm_q[ALARM_W-1:BUS_W]);
                A_CMP_LO: bus_rdata = cmp_q[BUS_W-1:0];
                A_CMP_HI: bus_rdata = BUS_W'(cmp_q[TIME_W-1:BUS_W]);
                A_DT_LO:  bus_rdata = count[BUS_W-1:0];
                A_DT_HI:  bus_rdata = BUS_W'(count[TIME_W-1:BUS_W]);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_checks.sv
module rtc_checks
    import rtc_pkg::*;
#(
    parameter int TW = 62
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input logic [7:0]    bus_addr,
    input logic [31:0]   bus_rdata,
    input logic [31:0]   bus_wdata,
    input logic          ctrl_wr,
    input logic          irq_o,
    input logic          run_q,
    input logic          tick,
    input logic [TW-1:0] count,
    input logic [TW-1:0] stage_q,
    input upl_state_t    upl_q,
    input logic          pend,
    input logic          arm_off,
    input logic          wake_en
);
    assert_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upl_q == UPL_COPY) |=> (count == $past(stage_q)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upl_q == UPL_IDLE && !tick) |=> $stable(count));

    assert_tick_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run_q);

    assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[C_STOP]) |=> !run_q);

    assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !arm_off) |=> pend);

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_en);

    assert_hi_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DT_HI) |-> (bus_rdata[31:30] == 2'b00));
endmodule

bind bin_rtc rtc_checks #(.TW(TIME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .ctrl_wr(ctrl_wr),
    .irq_o(irq_o), .run_q(run_q), .tick(tick), .count(count),
    .stage_q(stage_q), .upl_q(upl_q), .pend(pend), .arm_off(arm_off),
    .wake_en(wake_en)
);

// File: tb/bin_rtc_tb_top.sv
module bin_rtc_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string       req;
        logic [7:0]  addr;
        logic [31:0] exp;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    bin_rtc dut_i (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // every task is entered at a falling edge and uses exactly one cycle
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        exp_t it;
        it.req = req; it.addr = a; it.exp = e;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string req);
        #(CLK_P/4);
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s irq_o actual=%0b expected=%0b", req, irq_o, e);
        end
        @(negedge clk);
    endtask

    // monitor: pops expected read items and compares them
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (bus_rd) begin
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
                end else begin
                    exp_t it;
                    it = sb_q.pop_front();
                    if (bus_rdata !== it.exp) begin
                        errors++;
                        $display("FAIL %s addr=%h actual=%h expected=%h",
                                 it.req, it.addr, bus_rdata, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, 32'h0, "R1");
        rd(8'h04, 32'h0, "R1");
        rd(8'h20, 32'h0, "R1");
        rd(8'h24, 32'h0, "R1");
        chk_irq(1'b0, "R1");

        // R11 register widths
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h03FF_FFFF, "R11");
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0000_07FF, "R11");
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'h3FFF_FFFF, "R11");
        wr(8'h08, 32'd3);
        rd(8'h08, 32'd3, "R11");

        // R5 staged upload, R4 readback
        wr(8'h20, 32'd5);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h00, 32'h20);
        rd(8'h00, 32'h00, "R5");
        rd(8'h20, 32'd5, "R5");
        rd(8'h00, 32'h20, "R5");
        rd(8'h24, 32'h3FFF_FFFF, "R4");
        wr(8'h20, 32'd7);
        rd(8'h20, 32'd5, "R5");

        // R2 start/stop, R3 tick period
        wr(8'h24, 32'h0);
        wr(8'h20, 32'd10);
        wr(8'h00, 32'h20);
        idle(1);
        wr(8'h00, 32'h01);
        rd(8'h00, 32'h21, "R2");
        idle(2);
        rd(8'h20, 32'd10, "R3");
        rd(8'h20, 32'd11, "R3");
        idle(2);
        rd(8'h20, 32'd11, "R3");
        rd(8'h20, 32'd12, "R3");
        wr(8'h00, 32'h02);
        rd(8'h00, 32'h20, "R2");
        idle(5);
        rd(8'h20, 32'd12, "R2");
        wr(8'h00, 32'h03);
        rd(8'h00, 32'h20, "R2");

        // R3 no counting without ref_en
        ref_en = 1'b0;
        wr(8'h00, 32'h01);
        idle(10);
        rd(8'h20, 32'd12, "R3");
        rd(8'h00, 32'h21, "R3");
        wr(8'h00, 32'h02);
        ref_en = 1'b1;

        // R6 exact alarm, R9 continue, R8 gating, R7 clear
        wr(8'h20, 32'd20);
        wr(8'h00, 32'h20);
        idle(1);
        wr(8'h0C, 32'd22);
        wr(8'h10, 32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h18, 32'h3FFF_FFFF);
        wr(8'h04, 32'h0A);
        wr(8'h00, 32'h04);
        rd(8'h00, 32'h24, "R6");
        wr(8'h00, 32'h01);
        idle(7);
        chk_irq(1'b0, "R6");
        chk_irq(1'b1, "R6");
        rd(8'h20, 32'd22, "R6");
        idle(2);
        rd(8'h20, 32'd23, "R9");
        wr(8'h04, 32'h08);
        chk_irq(1'b0, "R8");
        wr(8'h04, 32'h0A);
        chk_irq(1'b1, "R8");
        wr(8'h00, 32'h08);
        chk_irq(1'b0, "R7");
        rd(8'h00, 32'h21, "R7");
        wr(8'h00, 32'h02);

        // R6 masked match, R9 halt, R10 calendar bit ignored
        wr(8'h20, 32'h10E);
        wr(8'h00, 32'h20);
        idle(1);
        wr(8'h0C, 32'h115);
        wr(8'h14, 32'hFFFF_FFF0);
        wr(8'h04, 32'h03);
        rd(8'h04, 32'h03, "R10");
        wr(8'h00, 32'h04);
        wr(8'h00, 32'h01);
        idle(4);
        rd(8'h20, 32'h10F, "R10");
        idle(2);
        chk_irq(1'b0, "R6");
        chk_irq(1'b1, "R6");
        rd(8'h20, 32'h110, "R10");
        rd(8'h00, 32'h24, "R9");
        idle(4);
        rd(8'h20, 32'h110, "R9");

        // R7 disarm on the same edge as a matching tick
        wr(8'h00, 32'h08);
        chk_irq(1'b0, "R7");
        wr(8'h04, 32'h0A);
        wr(8'h20, 32'h200);
        wr(8'h00, 32'h20);
        idle(1);
        wr(8'h0C, 32'h201);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'h04);
        wr(8'h00, 32'h01);
        idle(3);
        wr(8'h00, 32'h08);
        chk_irq(1'b0, "R7");
        rd(8'h00, 32'h21, "R7");
        rd(8'h20, 32'h201, "R7");
        wr(8'h00, 32'h02);

        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule